// File: doc/BRIEF.md
# Small Address-Translation Unit with TLB and Flat Page Table

This block turns 14-bit virtual addresses into 12-bit physical addresses, using 64-byte pages. A 16-entry translation cache holds recent translations. It has 4 sets of 4 ways. The low two bits of the virtual page number select the set, and the remaining six bits form the tag. A lookup that hits answers one clock after the request is accepted.

A lookup that misses spends one more cycle reading a 256-entry page table, which is indexed by the whole virtual page number. If that entry is valid, it supplies the translation and is installed in the cache. If it is not valid, the response carries a fault flag and the cache is left as it was.

Software fills the table through a one-entry-per-cycle write port. A flush input invalidates every cached translation in a single cycle. The 6-bit page offset is never translated.

Top module: `tiny_mmu`

## Requirements
- R1: A translated address is built from the physical page number in bits 11:6 and the request's offset bits 5:0, copied unchanged. For example, 0x03D4 maps to 0x354 when virtual page 0x0F maps to physical page 0x0D, and 0x0020 maps to 0xA20 when virtual page 0x00 maps to physical page 0x28.
- R2: A request is accepted when req_valid_i and ready_o are both high. A hit needs a valid entry in set vpn[1:0] whose tag equals vpn[7:2]. On a hit, resp_valid_o is high in the next cycle with resp_hit_o=1 and resp_fault_o=0.
- R3: On a miss, ready_o is low for exactly one cycle. The response arrives two cycles after acceptance with resp_hit_o=0, and its translation comes from the page table.
- R4: A miss that finds a valid page-table entry installs that translation, so a later request to the same page hits.
- R5: A miss that finds an invalid page-table entry returns resp_fault_o=1 and resp_paddr_o=0, and changes nothing in the cache. A repeated request to that page therefore misses again.
- R6: A refill goes to the lowest-numbered invalid way of its set. When the set is full, the refill goes to the way named by that set's rotating pointer. The pointer is 0 after reset and advances by one after each replacement in a full set.
- R7: A pulse on flush_i invalidates all cached entries at the next edge. If flush_i is high in the cycle a refill would be written, the refill is dropped, but the response is still delivered.
- R8: With pt_we_i high, entry pt_vpn_i of the table receives pt_ppn_i and pt_valid_i at the next edge. A walk in that same cycle reads the entry's previous content.
- R9: After reset, ready_o=1, resp_valid_o=0, the cache is empty and every page-table entry is invalid.
- R10: resp_valid_o is a one-cycle pulse for each accepted request. A request presented while ready_o is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 14 | Virtual address to translate |
| ready_o | output | 1 | High when a request can be accepted |
| resp_valid_o | output | 1 | Response pulse |
| resp_hit_o | output | 1 | Response came from the cache |
| resp_fault_o | output | 1 | Page-table entry was invalid |
| resp_paddr_o | output | 12 | Physical address, zero on a fault |
| pt_we_i | input | 1 | Page-table write strobe |
| pt_vpn_i | input | 8 | Page-table entry to write |
| pt_ppn_i | input | 6 | Physical page number to store |
| pt_valid_i | input | 1 | Valid bit to store |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is flush and refill. The bench raises flush_i in exactly the walk cycle of a successful miss. It then judges that the response still carries the table's translation, and that a repeat request misses again.

The second pair is the page-table write and the walk read. A write to the page being walked is issued in the walk cycle. The bench expects the old translation in that response and the new one after a flush forces a second walk.

A behavioural model in the bench predicts ready_o, the response pulse and its fields on every clock, including replacement order.

// File: rtl/tiny_mmu_pkg.sv
package tiny_mmu_pkg;
  parameter int VA_W  = 14;
  parameter int PA_W  = 12;
  parameter int OFF_W = 6;
  parameter int SETS  = 4;
  parameter int WAYS  = 4;

  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = VPN_W - IDX_W;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int PT_DEPTH = 1 << VPN_W;

  typedef enum logic {ST_IDLE, ST_WALK} mmu_state_e;
endpackage

// File: rtl/tiny_mmu_tlb.sv
module tiny_mmu_tlb
  import tiny_mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [IDX_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] victim;
  logic             has_free;

  assign lk_set   = lk_vpn_i[IDX_W-1:0];
  assign lk_tag   = lk_vpn_i[VPN_W-1:IDX_W];
  assign fill_set = fill_vpn_i[IDX_W-1:0];
  assign fill_tag = fill_vpn_i[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  assign lk_hit_o = |way_hit;

  always_comb begin
    lk_ppn_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) lk_ppn_o = lk_ppn_o | ppn_q[lk_set][w];
  end

  // lowest free way wins, else the rotating pointer
  always_comb begin
    victim   = rr_q[fill_set];
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[fill_set][w]) begin
        victim   = WAY_W'(w);
        has_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_q <= '0;
    else if (flush_i)   vld_q <= '0;
    else if (fill_en_i) vld_q[fill_set][victim] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill_en_i && !has_free) begin
      rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_set][victim] <= fill_tag;
      ppn_q[fill_set][victim] <= fill_ppn_i;
    end
  end
endmodule

// File: rtl/tiny_mmu_ptab.sv
module tiny_mmu_ptab
  import tiny_mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VPN_W-1:0] wvpn_i,
  input  logic [PPN_W-1:0] wppn_i,
  input  logic             wvalid_i,
  input  logic [VPN_W-1:0] rvpn_i,
  output logic [PPN_W-1:0] rppn_o,
  output logic             rvalid_o
);
  logic [PT_DEPTH-1:0] vld_q;
  logic [PPN_W-1:0]    ppn_q [PT_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[wvpn_i] <= wvalid_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) ppn_q[wvpn_i] <= wppn_i;
  end

  // combinational read: a same-cycle write is seen only after the edge
  assign rvalid_o = vld_q[rvpn_i];
  assign rppn_o   = ppn_q[rvpn_i];
endmodule

// File: rtl/tiny_mmu.sv
module tiny_mmu
  import tiny_mmu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  output logic            ready_o,
  output logic            resp_valid_o,
  output logic            resp_hit_o,
  output logic            resp_fault_o,
  output logic [PA_W-1:0] resp_paddr_o,
  input  logic            pt_we_i,
  input  logic [VPN_W-1:0] pt_vpn_i,
  input  logic [PPN_W-1:0] pt_ppn_i,
  input  logic            pt_valid_i
);
  mmu_state_e       state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [OFF_W-1:0] pend_off_q;
  logic             resp_valid_q, resp_hit_q, resp_fault_q;
  logic [PA_W-1:0]  resp_paddr_q;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             lk_hit, pt_valid, fill_en, accept, walking;
  logic [PPN_W-1:0] lk_ppn, pt_ppn;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];
  assign walking = (state_q == ST_WALK);
  assign accept  = req_valid_i && !walking;
  assign fill_en = walking && pt_valid && !flush_i;

  tiny_mmu_tlb u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .lk_vpn_i   (req_vpn),
    .lk_hit_o   (lk_hit),
    .lk_ppn_o   (lk_ppn),
    .fill_en_i  (fill_en),
    .fill_vpn_i (pend_vpn_q),
    .fill_ppn_i (pt_ppn)
  );

  tiny_mmu_ptab u_ptab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pt_we_i),
    .wvpn_i   (pt_vpn_i),
    .wppn_i   (pt_ppn_i),
    .wvalid_i (pt_valid_i),
    .rvpn_i   (pend_vpn_q),
    .rppn_o   (pt_ppn),
    .rvalid_o (pt_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_vpn_q   <= '0;
      pend_off_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_paddr_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      if (walking) begin
        state_q      <= ST_IDLE;
        resp_valid_q <= 1'b1;
        resp_hit_q   <= 1'b0;
        resp_fault_q <= !pt_valid;
        resp_paddr_q <= pt_valid ? {pt_ppn, pend_off_q} : '0;
      end else if (accept) begin
        if (lk_hit) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b1;
          resp_fault_q <= 1'b0;
          resp_paddr_q <= {lk_ppn, req_off};
        end else begin
          state_q    <= ST_WALK;
          pend_vpn_q <= req_vpn;
          pend_off_q <= req_off;
        end
      end
    end
  end

  assign ready_o      = !walking;
  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_fault_o = resp_fault_q;
  assign resp_paddr_o = resp_paddr_q;
endmodule

// File: rtl/tiny_mmu_chk.sv
module tiny_mmu_chk
  import tiny_mmu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            ready_o,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            resp_fault_o,
  input logic [PA_W-1:0] resp_paddr_o
);
  a_r1_hit_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_hit_o |->
      resp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]));

  a_r1_walk_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_hit_o && !resp_fault_o |->
      resp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0], 2));

  a_r2_hit_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_hit_o |-> $past(req_valid_i && ready_o));

  a_r3_walk_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o && resp_valid_o && !resp_hit_o);

  a_r5_fault_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o && resp_valid_o |-> !resp_hit_o && resp_paddr_o == '0);

  a_r10_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(!ready_o || req_valid_i));
endmodule

bind tiny_mmu tiny_mmu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (req_vaddr_i),
  .ready_o      (ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_fault_o (resp_fault_o),
  .resp_paddr_o (resp_paddr_o)
);

// File: tb/tiny_mmu_tb.sv
module tiny_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        ready, resp_valid, resp_hit, resp_fault;
  logic [11:0] resp_paddr;
  logic        pt_we = 1'b0;
  logic [7:0]  pt_vpn = '0;
  logic [5:0]  pt_ppn = '0;
  logic        pt_valid = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_tag = "R9";

  always #5 clk = ~clk;

  tiny_mmu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .ready_o(ready), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_fault_o(resp_fault), .resp_paddr_o(resp_paddr),
    .pt_we_i(pt_we), .pt_vpn_i(pt_vpn), .pt_ppn_i(pt_ppn), .pt_valid_i(pt_valid)
  );

  // behavioural reference model
  int m_v[4][4], m_tag[4][4], m_ppn[4][4], m_rr[4];
  int m_ptv[256], m_ptp[256];
  bit m_busy, e_valid, e_hit, e_fault;
  int m_pvpn, m_poff, e_pa;
  int t_vpn, t_set, t_tag, t_way;
  bit t_found;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[s, w]) m_v[s][w] = 0;
      foreach (m_rr[s]) m_rr[s] = 0;
      foreach (m_ptv[i]) m_ptv[i] = 0;
      m_busy = 0; e_valid = 0; e_hit = 0; e_fault = 0; e_pa = 0;
    end else begin
      e_valid = 0;
      if (m_busy) begin
        m_busy = 0; e_valid = 1; e_hit = 0;
        if (m_ptv[m_pvpn] != 0) begin
          e_fault = 0;
          e_pa = m_ptp[m_pvpn] * 64 + m_poff;
          if (!flush) begin
            t_set = m_pvpn % 4; t_tag = m_pvpn / 4; t_found = 0; t_way = 0;
            for (int w = 3; w >= 0; w--)
              if (m_v[t_set][w] == 0) begin t_way = w; t_found = 1; end
            if (!t_found) begin
              t_way = m_rr[t_set];
              m_rr[t_set] = (m_rr[t_set] + 1) % 4;
            end
            m_v[t_set][t_way] = 1; m_tag[t_set][t_way] = t_tag;
            m_ppn[t_set][t_way] = m_ptp[m_pvpn];
          end
        end else begin
          e_fault = 1; e_pa = 0;
        end
      end else if (req_valid) begin
        t_vpn = int'(req_vaddr) / 64;
        t_set = t_vpn % 4; t_tag = t_vpn / 4; t_found = 0;
        for (int w = 0; w < 4; w++)
          if (m_v[t_set][w] != 0 && m_tag[t_set][w] == t_tag) begin
            t_found = 1; e_pa = m_ppn[t_set][w] * 64 + int'(req_vaddr) % 64;
          end
        if (t_found) begin
          e_valid = 1; e_hit = 1; e_fault = 0;
        end else begin
          m_busy = 1; m_pvpn = t_vpn; m_poff = int'(req_vaddr) % 64;
        end
      end
      if (flush) foreach (m_v[s, w]) m_v[s][w] = 0;
      if (pt_we) begin m_ptv[pt_vpn] = int'(pt_valid); m_ptp[pt_vpn] = int'(pt_ppn); end
    end
  end

  task automatic check(input bit ok, input string tg, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tg, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ready == !m_busy, cur_tag, "model ready", int'(ready), int'(!m_busy));
      check(resp_valid == e_valid, cur_tag, "model resp_valid", int'(resp_valid), int'(e_valid));
      if (resp_valid && e_valid) begin
        check(resp_hit == e_hit, cur_tag, "model hit", int'(resp_hit), int'(e_hit));
        check(resp_fault == e_fault, cur_tag, "model fault", int'(resp_fault), int'(e_fault));
        check(int'(resp_paddr) == e_pa, cur_tag, "model paddr", int'(resp_paddr), e_pa);
      end
    end
  end

  task automatic pt_write(input int vpn, input int ppn, input bit v);
    @(negedge clk);
    pt_we = 1; pt_vpn = 8'(vpn); pt_ppn = 6'(ppn); pt_valid = v;
    @(negedge clk);
    pt_we = 0;
  endtask

  task automatic lookup(input int a, input string tg, input bit xh, input bit xf, input int xpa);
    int lat;
    cur_tag = tg;
    @(negedge clk);
    req_valid = 1; req_vaddr = 14'(a);
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!resp_valid && lat < 4) begin @(negedge clk); lat++; end
    check(resp_valid, tg, "response seen", int'(resp_valid), 1);
    check(lat == (xh ? 1 : 2), tg, "latency", lat, xh ? 1 : 2);
    check(resp_hit == xh && resp_fault == xf, tg, "hit/fault", {resp_hit, resp_fault}, {xh, xf});
    check(int'(resp_paddr) == xpa, tg, "paddr", int'(resp_paddr), xpa);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready == 1 && resp_valid == 0, "R9", "reset outputs", {ready, resp_valid}, 2'b10);
    lookup(14'h03D4, "R9", 0, 1, 0);

    pt_write(8'h0F, 6'h0D, 1);
    pt_write(8'h00, 6'h28, 1);
    pt_write(8'h04, 6'h11, 1);
    pt_write(8'h08, 6'h13, 1);
    pt_write(8'h0C, 6'h15, 1);
    pt_write(8'h10, 6'h17, 1);
    pt_write(8'h02, 6'h3A, 0);

    lookup(14'h0020, "R3", 0, 0, 12'hA20);
    lookup(14'h0020, "R4", 1, 0, 12'hA20);
    lookup(14'h03D4, "R3", 0, 0, 12'h354);
    lookup(14'h03D4, "R1", 1, 0, 12'h354);
    lookup(14'h03D5, "R2", 1, 0, 12'h355);

    // fill set 0, then replace in rotation
    lookup(14'h0100, "R6", 0, 0, 12'h440);
    lookup(14'h0200, "R6", 0, 0, 12'h4C0);
    lookup(14'h0300, "R6", 0, 0, 12'h540);
    lookup(14'h0400, "R6", 0, 0, 12'h5C0);
    lookup(14'h0104, "R6", 1, 0, 12'h444);
    lookup(14'h0020, "R6", 0, 0, 12'hA20);
    lookup(14'h0100, "R6", 0, 0, 12'h440);
    lookup(14'h0300, "R6", 1, 0, 12'h540);

    lookup(14'h0080, "R5", 0, 1, 0);
    lookup(14'h0080, "R5", 0, 1, 0);

    @(negedge clk); flush = 1; cur_tag = "R7";
    @(negedge clk); flush = 0;
    lookup(14'h03D4, "R7", 0, 0, 12'h354);

    // flush lands in the walk cycle: refill dropped
    @(negedge clk); req_valid = 1; req_vaddr = 14'h0400;
    @(negedge clk); req_valid = 0; flush = 1;
    @(negedge clk); flush = 0;
    check(resp_valid && !resp_hit && resp_paddr == 12'h5C0, "R7", "flush+refill resp",
          int'(resp_paddr), 12'h5C0);
    lookup(14'h0400, "R7", 0, 0, 12'h5C0);

    // table write lands in the walk cycle: old entry used
    cur_tag = "R8";
    @(negedge clk); req_valid = 1; req_vaddr = 14'h03D4;
    @(negedge clk); req_valid = 0;
    pt_we = 1; pt_vpn = 8'h0F; pt_ppn = 6'h3F; pt_valid = 1;
    @(negedge clk); pt_we = 0;
    check(resp_valid && resp_paddr == 12'h354, "R8", "walk reads old", int'(resp_paddr), 12'h354);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    lookup(14'h03D4, "R8", 0, 0, 12'hFD4);

    // request held during walk is ignored
    cur_tag = "R10";
    @(negedge clk); req_valid = 1; req_vaddr = 14'h0020;
    @(negedge clk); req_vaddr = 14'h0080;
    check(ready == 0, "R3", "busy during walk", int'(ready), 0);
    @(negedge clk); req_valid = 0;
    check(resp_valid && resp_paddr == 12'hA20, "R10", "first request answered", int'(resp_paddr), 12'hA20);
    @(negedge clk);
    check(resp_valid == 0 && ready == 1, "R10", "single pulse, second ignored",
          {resp_valid, ready}, 2'b01);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule